// File: doc/BRIEF.md
# Joint-State Outcome Histogram

This block accumulates the distribution of joint readout results for a group of qubits that are measured together. Each readout delivers a k-bit word, one bit per qubit, with a strobe. The word is used directly as the address of a counter, and that counter is incremented. After a run of N repeated readouts, the host reads the counters back and divides each count n by N to get the probability of that joint state. Raw shots never leave the block; only 2^k counts are read out.

The counters sit in a 2^k-entry memory that is updated by read-modify-write. A clear command, and reset, sweep zeros through every entry, one entry per cycle, and a busy flag is high during the sweep. A programmable repetition target stops accumulation once that many outcomes have been counted. The default configuration covers ten qubits with 32-bit saturating counters.

Top module: `hist_counter_top`

## Requirements
- R1: After reset, busy is high while the memory is being zeroed. When busy falls, every entry reads zero, rep_count is zero and done is low.
- R2: Each accepted outcome adds one to the entry whose address equals shot_word, where bit i of the word is the result of qubit i. No other entry changes.
- R3: Outcomes accepted on consecutive cycles with the same word are all counted, with no increment lost.
- R4: An entry that holds the maximum value 2^CNT_W-1 stays at that value when incremented again.
- R5: A clear_req seen while not busy raises busy from the next cycle for exactly 2^QUBITS cycles. It zeroes every entry and sets rep_count to zero and done low.
- R6: An outcome is ignored while busy is high, and also in the cycle in which clear_req is high.
- R7: rep_count rises by one for each accepted outcome. When rep_target is non-zero, done rises at the same clock edge at which rep_count reaches rep_target.
- R8: While done is high, outcomes are ignored and rep_count holds, until the next clear.
- R9: rd_data returns the entry at the rd_addr present at the previous clock edge, with one cycle of latency.
- R10: When rep_target is zero, done never rises and every outcome is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shot_valid | input | 1 | Outcome strobe |
| shot_word | input | QUBITS | Joint outcome word, bit i is qubit i |
| clear_req | input | 1 | Starts a zeroing sweep of all counters |
| rep_target | input | REP_W | Number of outcomes per run, 0 means unlimited |
| busy | output | 1 | High while the zeroing sweep is in progress |
| done | output | 1 | High once rep_target outcomes have been counted |
| rep_count | output | REP_W | Outcomes counted since the last clear |
| rd_addr | input | QUBITS | Host read address |
| rd_data | output | CNT_W | Count at the read address, one cycle later |

## Verification
The hardest case to reach is the read-modify-write hazard. An outcome reads its entry one cycle before the update from the previous outcome to the same entry has been written. Only an unbroken burst of identical words at full strobe rate exposes this hazard, so the bench sends bursts of each word back to back. It also holds one word for more strobes than the counter can represent, which drives the counter into saturation through the forwarding path. Outcomes are also sent during the clear cycle, during the sweep and after done, and the memory is then read back to show that none of them left a trace.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic {
    SWEEP_IDLE = 1'b0,
    SWEEP_RUN  = 1'b1
  } sweep_state_e;
endpackage

// File: rtl/hist_rst_sync.sv
module hist_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/hist_clear_seq.sv
module hist_clear_seq
  import hist_pkg::*;
#(
  parameter int QUBITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_req,
  output logic              busy,
  output logic              clr_start,
  output logic [QUBITS-1:0] clr_addr
);
  localparam logic [QUBITS-1:0] LAST_IDX = '1;

  sweep_state_e      state_q, state_d;
  logic [QUBITS-1:0] idx_q, idx_d;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    clr_start = 1'b0;
    if (state_q == SWEEP_RUN) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == LAST_IDX) state_d = SWEEP_IDLE;
    end else if (clear_req) begin
      clr_start = 1'b1;
      state_d   = SWEEP_RUN;
      idx_d     = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SWEEP_RUN;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign busy     = (state_q == SWEEP_RUN);
  assign clr_addr = idx_q;
endmodule

// File: rtl/hist_rep_ctrl.sv
module hist_rep_ctrl #(
  parameter int REP_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shot_valid,
  input  logic             busy,
  input  logic             clear_req,
  input  logic             clr_start,
  input  logic [REP_W-1:0] rep_target,
  output logic             accept,
  output logic [REP_W-1:0] rep_count,
  output logic             done
);
  logic [REP_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             done_q, done_d;

  assign accept  = shot_valid && !busy && !clear_req && !done_q;
  assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (clr_start) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (accept) begin
      cnt_d = cnt_inc;
      if ((rep_target != '0) && (cnt_inc == rep_target)) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign rep_count = cnt_q;
  assign done      = done_q;
endmodule

// File: rtl/hist_count_ram.sv
module hist_count_ram #(
  parameter int QUBITS = 10,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [QUBITS-1:0] shot_word,
  input  logic              busy,
  input  logic [QUBITS-1:0] clr_addr,
  input  logic [QUBITS-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data
);
  localparam int DEPTH = 1 << QUBITS;

  logic [CNT_W-1:0]  mem [DEPTH];
  logic [CNT_W-1:0]  look_q;
  logic [CNT_W-1:0]  rd_q;

  logic              s1_vld_q, s1_vld_d;
  logic [QUBITS-1:0] s1_addr_q, s1_addr_d;
  logic              fw_vld_q, fw_vld_d;
  logic [QUBITS-1:0] fw_addr_q, fw_addr_d;
  logic [CNT_W-1:0]  fw_data_q, fw_data_d;

  logic [CNT_W-1:0]  base, bumped;
  logic              we;
  logic [QUBITS-1:0] waddr;
  logic [CNT_W-1:0]  wdata;

  // stage 1: take the freshest copy of the entry, bump it, write it back
  always_comb begin
    base   = (fw_vld_q && (fw_addr_q == s1_addr_q)) ? fw_data_q : look_q;
    bumped = (base == '1) ? base : base + 1'b1;
    we     = busy || s1_vld_q;
    waddr  = busy ? clr_addr : s1_addr_q;
    wdata  = busy ? '0 : bumped;
    s1_vld_d  = accept;
    s1_addr_d = accept ? shot_word : s1_addr_q;
    fw_vld_d  = s1_vld_q && !busy;
    fw_addr_d = s1_vld_q ? s1_addr_q : fw_addr_q;
    fw_data_d = s1_vld_q ? bumped : fw_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q  <= 1'b0;
      s1_addr_q <= '0;
      fw_vld_q  <= 1'b0;
      fw_addr_q <= '0;
      fw_data_q <= '0;
    end else begin
      s1_vld_q  <= s1_vld_d;
      s1_addr_q <= s1_addr_d;
      fw_vld_q  <= fw_vld_d;
      fw_addr_q <= fw_addr_d;
      fw_data_q <= fw_data_d;
    end
  end

  // storage array without reset; zeroed by the sweep
  always_ff @(posedge clk) begin
    if (we)     mem[waddr] <= wdata;
    if (accept) look_q     <= mem[shot_word];
    rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/hist_counter_top.sv
module hist_counter_top #(
  parameter int QUBITS = 10,
  parameter int CNT_W  = 32,
  parameter int REP_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shot_valid,
  input  logic [QUBITS-1:0] shot_word,
  input  logic              clear_req,
  input  logic [REP_W-1:0]  rep_target,
  output logic              busy,
  output logic              done,
  output logic [REP_W-1:0]  rep_count,
  input  logic [QUBITS-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data
);
  logic              rst_s_n;
  logic              clr_start;
  logic [QUBITS-1:0] clr_addr;
  logic              accept;

  hist_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  hist_clear_seq #(.QUBITS(QUBITS)) u_clr (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .clear_req (clear_req),
    .busy      (busy),
    .clr_start (clr_start),
    .clr_addr  (clr_addr)
  );

  hist_rep_ctrl #(.REP_W(REP_W)) u_rep (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .shot_valid (shot_valid),
    .busy       (busy),
    .clear_req  (clear_req),
    .clr_start  (clr_start),
    .rep_target (rep_target),
    .accept     (accept),
    .rep_count  (rep_count),
    .done       (done)
  );

  hist_count_ram #(.QUBITS(QUBITS), .CNT_W(CNT_W)) u_ram (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .accept    (accept),
    .shot_word (shot_word),
    .busy      (busy),
    .clr_addr  (clr_addr),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/hist_counter_chk.sv
module hist_counter_chk #(
  parameter int QUBITS = 10,
  parameter int REP_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shot_valid,
  input logic             clear_req,
  input logic [REP_W-1:0] rep_target,
  input logic             busy,
  input logic             done,
  input logic [REP_W-1:0] rep_count
);
  localparam int DEPTH = 1 << QUBITS;

  logic [QUBITS:0] bcnt_q;
  logic            acc_w;

  assign acc_w = shot_valid && !busy && !clear_req && !done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt_q <= '0;
    else if (busy) bcnt_q <= bcnt_q + 1'b1;
    else           bcnt_q <= '0;
  end

  p_sweep_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(bcnt_q) < DEPTH));

  p_sweep_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (int'(bcnt_q) == DEPTH - 1)) |=> !busy);

  p_busy_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((rep_count == '0) && !done));

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_w && (rep_count != '1)) |=> (rep_count == $past(rep_count) + 1'b1));

  p_done_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ((rep_count == rep_target) && (rep_target != '0)));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clear_req) |=> (done && $stable(rep_count)));
endmodule

bind hist_counter_top hist_counter_chk #(.QUBITS(QUBITS), .REP_W(REP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_s_n),
  .shot_valid (shot_valid),
  .clear_req  (clear_req),
  .rep_target (rep_target),
  .busy       (busy),
  .done       (done),
  .rep_count  (rep_count)
);

// File: tb/sim_hist_counter_top.sv
`timescale 1ns/1ps
module sim_hist_counter_top;
  localparam int QB    = 3;
  localparam int CW    = 4;
  localparam int RW    = 8;
  localparam int NENT  = 1 << QB;
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          shot_valid;
  logic [QB-1:0] shot_word;
  logic          clear_req;
  logic [RW-1:0] rep_target;
  logic          busy, done;
  logic [RW-1:0] rep_count;
  logic [QB-1:0] rd_addr;
  logic [CW-1:0] rd_data;

  int ntests = 0;
  int nfail  = 0;
  int expv [NENT];
  int exp_reps = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hist_counter_top #(.QUBITS(QB), .CNT_W(CW), .REP_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .shot_valid(shot_valid), .shot_word(shot_word),
    .clear_req(clear_req), .rep_target(rep_target), .busy(busy), .done(done),
    .rep_count(rep_count), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input int act, input int want);
    ntests++;
    if (act != want) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, want);
    end
  endtask

  task automatic send(input int w, input bit counts);
    shot_word  = w[QB-1:0];
    shot_valid = 1'b1;
    @(negedge clk);
    shot_valid = 1'b0;
    if (counts) begin
      if (expv[w] < CMAX) expv[w]++;
      exp_reps++;
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < NENT; a++) begin
      rd_addr = a[QB-1:0];
      @(negedge clk);
      chk(req, int'(rd_data), expv[a]);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic zero_model();
    for (int a = 0; a < NENT; a++) expv[a] = 0;
    exp_reps = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; shot_valid = 1'b0; shot_word = '0; clear_req = 1'b0;
    rep_target = '0; rd_addr = '0;
    zero_model();
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 1);
    wait_idle();
    chk("R1 rep_count", int'(rep_count), 0);
    chk("R1 done", int'(done), 0);
    read_all("R1 zero entries");

    // R2 R3 R10: bursts of identical words, then a scattered pattern
    for (int w = 0; w < NENT; w++)
      for (int k = 0; k <= w; k++) send(w, 1'b1);
    for (int i = 0; i < 24; i++) send((i * 5) % NENT, 1'b1);
    settle();
    read_all("R2 R3 burst and scatter");
    chk("R10 rep_count no target", int'(rep_count), exp_reps);
    chk("R10 done stays low", int'(done), 0);

    // R4: push word 5 far past the counter limit, back to back
    for (int i = 0; i < 20; i++) send(5, 1'b1);
    settle();
    rd_addr = 3'd5; @(negedge clk);
    chk("R4 saturated entry", int'(rd_data), CMAX);
    read_all("R4 others untouched");

    // R9: one cycle read latency
    rd_addr = 3'd0; @(negedge clk);
    rd_addr = 3'd7; #1;
    chk("R9 data before edge", int'(rd_data), expv[0]);
    @(negedge clk);
    chk("R9 data after edge", int'(rd_data), expv[7]);

    // R5 R6: clear with outcomes in the clear cycle and during the sweep
    clear_req = 1'b1; shot_word = 3'd1; shot_valid = 1'b1;
    @(negedge clk);
    clear_req = 1'b0;
    begin
      int cnt = 0;
      while (busy) begin
        cnt++;
        shot_word = cnt[QB-1:0];
        @(negedge clk);
      end
      chk("R5 sweep length", cnt, NENT);
    end
    shot_valid = 1'b0;
    zero_model();
    settle();
    chk("R6 rep_count after clear", int'(rep_count), 0);
    chk("R5 done after clear", int'(done), 0);
    read_all("R6 R5 entries zero");

    // R7 R8: target of 5
    rep_target = 8'd5;
    send(7, 1'b1); send(7, 1'b1); send(2, 1'b1); send(3, 1'b1);
    chk("R7 done before target", int'(done), 0);
    send(7, 1'b1);
    chk("R7 done at target", int'(done), 1);
    chk("R7 rep_count at target", int'(rep_count), 5);
    send(0, 1'b0); send(7, 1'b0); send(1, 1'b0); send(1, 1'b0);
    settle();
    chk("R8 rep_count held", int'(rep_count), 5);
    chk("R8 done held", int'(done), 1);
    read_all("R8 late outcomes ignored");

    // R8: the next clear reopens counting
    clear_req = 1'b1; @(negedge clk); clear_req = 1'b0;
    wait_idle();
    zero_model();
    chk("R8 done cleared", int'(done), 0);
    send(4, 1'b1);
    settle();
    chk("R8 counting resumes", int'(rep_count), 1);
    read_all("R2 after reopen");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule